// File: doc/BRIEF.md
# GPIO Pad Configuration and Event Detector

This block controls one general-purpose I/O pad. Software reaches it through two 32-bit configuration words on a simple register bus with a combinational read path. The first word selects the pad function, the buffer disables, the driven output level, the input inversion and the event type. It also holds four stored routing enables. Bit 1 of that word reads back the current pad input. The second word stores a pull-termination code and a pull-up select. The block only passes these two fields to the board and never acts on them.

The pad input first passes through a synchronizer. It is then optionally forced low when the receive buffer is off, and then optionally inverted. The result feeds an event detector. The detector can hold its output for a level, pulse it for a single edge or for both edges, or stay silent. A downstream interrupt status register collects the event output. Falling-edge and low-level detection are the rising-edge and high-level modes with the invert bit set.

Top module: `gpio_pad_cfg`

## Requirements
- R1: After reset, word 0 (byte offset 0) reads 0x0400_0100: event type disabled, transmit disabled, everything else zero. Word 1 (byte offset 4) reads 0. `padOe` and `eventOut` are low.
- R2: Word 0 stores the following fields, and every other bit reads 0:
  - event type at bits 26:25
  - invert at bit 23
  - routing enables at bits 20:17
  - pad mode at bits 13:10
  - receive-off at bit 9
  - transmit-off at bit 8
  - output level at bit 0

  Word 1 stores the termination code at bits 12:10 and pull-up at bit 13, and every other bit reads 0. Writing all ones reads back 0x069E_3F01 and 0x0000_3C00.
- R3: Word 0 bit 1 reads the pad input two clocks after it changes. It reads 0 while receive-off is set. Writes to bit 1 have no effect on its value.
- R4: The bus decodes only byte offsets 0 and 4. A write to any other offset changes nothing, and a read of it returns 0.
- R5: `padOe` is the inverse of the transmit-off bit, and `padOut` follows the output-level bit, both one clock after the write.
- R6: With event type 0 (level), `eventOut` stays high for as long as the detector input is high. It rises two clocks after a rising pad input.
- R7: With event type 1 (edge), `eventOut` is high for exactly one clock, two clocks after each rising detector input. Falling inputs give nothing.
- R8: The invert bit flips the detector input. Edge mode with invert set pulses on falling pad edges, and level mode with invert set holds while the pad is low.
- R9: With event type 3 (both edges), each change of the detector input gives a one-clock pulse. Changes on consecutive clocks give consecutive pulses.
- R10: With event type 2 (disabled), `eventOut` never asserts, whatever the input or the invert bit.
- R11: While receive-off is set, the detector sees 0 ahead of the invert bit. In inverted level mode the event is held regardless of the pad; in plain level mode it stays low.
- R12: `padMode`, `termCode` and `termPullUp` show the stored mode, termination code and pull-up fields one clock after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte offset within the pad slot |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read enable for the combinational read path |
| busWData | input | DATA_W | Write data |
| busRData | output | DATA_W | Read data, 0 when not reading a decoded word |
| padIn | input | 1 | Asynchronous pad input level |
| padOut | output | 1 | Level driven on the pad |
| padOe | output | 1 | Pad output enable |
| padMode | output | 4 | Stored pad function, 0 for GPIO |
| termCode | output | 3 | Stored termination code |
| termPullUp | output | 1 | Stored pull-up select |
| eventOut | output | 1 | Event to the interrupt status register |

## Verification
The detector is tried with several input patterns:
- Isolated slow rising and falling transitions, which separate the edge, inverted edge and both-edge codes.
- An input held high for several clocks, which separates level holding from single pulses.
- A rise followed at once by a fall, which shows that both-edge mode gives back-to-back pulses rather than merging them.

The same patterns are repeated with detection disabled and with the receive buffer off. This shows that the synchronized input, and not the pad, reaches the detector, and that the receive gate sits ahead of the inverter. Read-back of the input bit is timed against the two-stage synchronizer.

// File: rtl/gpad_pkg.sv
`timescale 1ns/1ps
package gpad_pkg;

  // word 0 field positions
  localparam int EVT_LO  = 25;
  localparam int INV_BIT = 23;
  localparam int RTE_LO  = 17;
  localparam int MODE_LO = 10;
  localparam int RXD_BIT = 9;
  localparam int TXD_BIT = 8;
  localparam int RXS_BIT = 1;
  localparam int TXS_BIT = 0;

  // word 1 field positions
  localparam int TERM_LO = 10;
  localparam int PUP_BIT = 13;

  localparam int MODE_W = 4;
  localparam int RTE_W  = 4;
  localparam int TERM_W = 3;

  typedef enum logic [1:0] {
    EV_LEVEL = 2'd0,
    EV_EDGE  = 2'd1,
    EV_OFF   = 2'd2,
    EV_BOTH  = 2'd3
  } evKind_e;

  typedef struct packed {
    logic wrMain;
    logic wrTerm;
    logic rdMain;
    logic rdTerm;
  } busStrb_t;

  typedef struct packed {
    evKind_e            evKind;
    logic               rxInv;
    logic [RTE_W-1:0]   route;
    logic [MODE_W-1:0]  mode;
    logic               rxOff;
    logic               txOff;
    logic               txLevel;
  } mainCfg_t;

  typedef struct packed {
    logic              pullUp;
    logic [TERM_W-1:0] term;
  } termCfg_t;

endpackage

// File: rtl/gpad_ctrl.sv
`timescale 1ns/1ps
module gpad_ctrl
  import gpad_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output busStrb_t          strb
);
  localparam logic [ADDR_W-1:0] OFS_MAIN = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_TERM = ADDR_W'(4);

  logic hitMain;
  logic hitTerm;

  assign hitMain = (busAddr == OFS_MAIN);
  assign hitTerm = (busAddr == OFS_TERM);

  always_comb begin
    strb.wrMain = busWe & hitMain;
    strb.wrTerm = busWe & hitTerm;
    strb.rdMain = busRe & hitMain;
    strb.rdTerm = busRe & hitTerm;
  end
endmodule

// File: rtl/gpad_evt.sv
`timescale 1ns/1ps
module gpad_evt
  import gpad_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    padIn,
  input  logic    rxOff,
  input  logic    rxInv,
  input  evKind_e evKind,
  output logic    rxState,
  output logic    eventOut
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic detIn;
  logic detPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], padIn};
  end

  assign rxState = syncQ[SYNC_STAGES-1] & ~rxOff;
  assign detIn   = rxState ^ rxInv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) detPrev <= 1'b0;
    else       detPrev <= detIn;
  end

  always_comb begin
    unique case (evKind)
      EV_LEVEL: eventOut = detIn;
      EV_EDGE:  eventOut = detIn & ~detPrev;
      EV_BOTH:  eventOut = detIn ^ detPrev;
      default:  eventOut = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpad_datapath.sv
`timescale 1ns/1ps
module gpad_datapath
  import gpad_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrb_t          strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              padIn,
  output logic              padOut,
  output logic              padOe,
  output logic [MODE_W-1:0] padMode,
  output logic [TERM_W-1:0] termCode,
  output logic              termPullUp,
  output evKind_e           cfgEvKind,
  output logic              eventOut
);
  mainCfg_t mainQ;
  termCfg_t termQ;
  logic     rxState;
  logic [DATA_W-1:0] mainView;
  logic [DATA_W-1:0] termView;
  logic     unusedWrBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainQ        <= '0;
      mainQ.evKind <= EV_OFF;
      mainQ.txOff  <= 1'b1;
    end else if (strb.wrMain) begin
      mainQ.evKind  <= evKind_e'(wrData[EVT_LO +: 2]);
      mainQ.rxInv   <= wrData[INV_BIT];
      mainQ.route   <= wrData[RTE_LO +: RTE_W];
      mainQ.mode    <= wrData[MODE_LO +: MODE_W];
      mainQ.rxOff   <= wrData[RXD_BIT];
      mainQ.txOff   <= wrData[TXD_BIT];
      mainQ.txLevel <= wrData[TXS_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) termQ <= '0;
    else if (strb.wrTerm) begin
      termQ.pullUp <= wrData[PUP_BIT];
      termQ.term   <= wrData[TERM_LO +: TERM_W];
    end
  end

  // bits of the write word that no field takes
  assign unusedWrBits = ^wrData;

  gpad_evt #(.SYNC_STAGES(SYNC_STAGES)) uEvt (
    .clk      (clk),
    .rstN     (rstN),
    .padIn    (padIn),
    .rxOff    (mainQ.rxOff),
    .rxInv    (mainQ.rxInv),
    .evKind   (mainQ.evKind),
    .rxState  (rxState),
    .eventOut (eventOut)
  );

  always_comb begin
    mainView                       = '0;
    mainView[EVT_LO +: 2]          = mainQ.evKind;
    mainView[INV_BIT]              = mainQ.rxInv;
    mainView[RTE_LO +: RTE_W]      = mainQ.route;
    mainView[MODE_LO +: MODE_W]    = mainQ.mode;
    mainView[RXD_BIT]              = mainQ.rxOff;
    mainView[TXD_BIT]              = mainQ.txOff;
    mainView[RXS_BIT]              = rxState;
    mainView[TXS_BIT]              = mainQ.txLevel;
    termView                       = '0;
    termView[PUP_BIT]              = termQ.pullUp;
    termView[TERM_LO +: TERM_W]    = termQ.term;
  end

  always_comb begin
    if (strb.rdMain)      rdData = mainView;
    else if (strb.rdTerm) rdData = termView;
    else                  rdData = '0;
  end

  assign padOut     = mainQ.txLevel;
  assign padOe      = ~mainQ.txOff;
  assign padMode    = mainQ.mode;
  assign termCode   = termQ.term;
  assign termPullUp = termQ.pullUp;
  assign cfgEvKind  = mainQ.evKind;
endmodule

// File: rtl/gpio_pad_cfg.sv
`timescale 1ns/1ps
module gpio_pad_cfg
  import gpad_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  input  logic              padIn,
  output logic              padOut,
  output logic              padOe,
  output logic [3:0]        padMode,
  output logic [2:0]        termCode,
  output logic              termPullUp,
  output logic              eventOut
);
  busStrb_t strb;
  evKind_e  cfgEvKind;

  gpad_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .strb    (strb)
  );

  gpad_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (busWData),
    .rdData     (busRData),
    .padIn      (padIn),
    .padOut     (padOut),
    .padOe      (padOe),
    .padMode    (padMode),
    .termCode   (termCode),
    .termPullUp (termPullUp),
    .cfgEvKind  (cfgEvKind),
    .eventOut   (eventOut)
  );
endmodule

// File: rtl/gpad_chk.sv
`timescale 1ns/1ps
module gpad_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              busRe,
  input logic [DATA_W-1:0] busWData,
  input logic [DATA_W-1:0] busRData,
  input logic              padIn,
  input logic              padOut,
  input logic              padOe,
  input logic [3:0]        padMode,
  input logic [2:0]        termCode,
  input logic [1:0]        cfgEvKind,
  input logic              eventOut
);
  logic [1:0] upCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             upCnt <= 2'd0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  // R10: disabled detector stays silent
  a_r10_off_silent: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEvKind == 2'd2) |-> !eventOut);

  // R5: clearing transmit-off enables the output next clock
  a_r5_oe_on_write: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(0) && !busWData[8]) |=> padOe);

  // R7: an edge-mode event lasts one clock
  a_r7_edge_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEvKind == 2'd1 && eventOut && !busWe) |=> !eventOut);

  // R3: read-back bit trails the pad by two clocks
  a_r3_rx_reflect: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd2 && busRe && busAddr == ADDR_W'(0) && !busRData[9])
      |-> busRData[1] == $past(padIn, 2));

  // R4: writes outside the decoded offsets change nothing
  a_r4_bad_addr: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr != ADDR_W'(0) && busAddr != ADDR_W'(4))
      |=> ($stable(padMode) && $stable(padOut) && $stable(padOe) && $stable(termCode)));
endmodule

bind gpio_pad_cfg gpad_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWe     (busWe),
  .busRe     (busRe),
  .busWData  (busWData),
  .busRData  (busRData),
  .padIn     (padIn),
  .padOut    (padOut),
  .padOe     (padOe),
  .padMode   (padMode),
  .termCode  (termCode),
  .cfgEvKind (cfgEvKind),
  .eventOut  (eventOut)
);

// File: tb/sim_gpio_pad_cfg.sv
`timescale 1ns/1ps
module sim_gpio_pad_cfg;
  localparam int SEL_RD = 0, SEL_EV = 1, SEL_OE = 2, SEL_OUT = 3,
                 SEL_MODE = 4, SEL_TERM = 5, SEL_PUP = 6;

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        padIn = 1'b0;
  logic        padOut, padOe, termPullUp, eventOut;
  logic [3:0]  padMode;
  logic [2:0]  termCode;

  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  item_t sb[$];

  gpio_pad_cfg u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWData(busWData), .busRData(busRData), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .padMode(padMode), .termCode(termCode),
    .termPullUp(termPullUp), .eventOut(eventOut)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [31:0] pick(int sel);
    case (sel)
      SEL_RD:   return busRData;
      SEL_EV:   return {31'b0, eventOut};
      SEL_OE:   return {31'b0, padOe};
      SEL_OUT:  return {31'b0, padOut};
      SEL_MODE: return {28'b0, padMode};
      SEL_TERM: return {29'b0, termCode};
      default:  return {31'b0, termPullUp};
    endcase
  endfunction

  // monitor: compare every item due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic [31:0] act;
        act = pick(sb[i].sel);
        total++;
        if (act !== sb[i].exp) begin
          bad++;
          $display("FAIL %s sel=%0d act=%h exp=%h cyc=%0d",
                   sb[i].tag, sb[i].sel, act, sb[i].exp, cyc);
        end
        sb.delete(i);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic want(int sel, logic [31:0] v, string tag, int dly);
    item_t it;
    it.due = cyc + dly; it.sel = sel; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    busAddr = a; busWData = d; busWe = 1'b1;
    tick();
    busWe = 1'b0;
  endtask

  task automatic chkRd(logic [2:0] a, logic [31:0] v, string tag);
    busAddr = a; busRe = 1'b1;
    want(SEL_RD, v, tag, 0);
    tick();
    busRe = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick();

    // R1 reset state
    chkRd(3'd0, 32'h0400_0100, "R1");
    chkRd(3'd4, 32'h0, "R1");
    want(SEL_EV, 0, "R1", 0);
    want(SEL_OE, 0, "R1", 0);
    tick();

    // R2 field masks, R12 stored outputs
    wr(3'd0, 32'hFFFF_FFFF);
    want(SEL_MODE, 4'hF, "R12", 0);
    want(SEL_OE, 0, "R5", 0);
    want(SEL_OUT, 1, "R5", 0);
    chkRd(3'd0, 32'h069E_3F01, "R2");
    wr(3'd4, 32'hFFFF_FFFF);
    want(SEL_TERM, 7, "R12", 0);
    want(SEL_PUP, 1, "R12", 0);
    chkRd(3'd4, 32'h0000_3C00, "R2");
    wr(3'd4, 32'h0000_3000);
    want(SEL_TERM, 4, "R12", 0);
    want(SEL_PUP, 1, "R12", 0);
    tick();
    wr(3'd4, 32'h0000_0800);
    want(SEL_TERM, 2, "R12", 0);
    want(SEL_PUP, 0, "R12", 0);
    chkRd(3'd4, 32'h0000_0800, "R12");

    // R4 undecoded offsets
    wr(3'd1, 32'h0);
    wr(3'd6, 32'h0);
    wr(3'd3, 32'h0);
    chkRd(3'd0, 32'h069E_3F01, "R4");
    chkRd(3'd4, 32'h0000_0800, "R4");
    chkRd(3'd2, 32'h0, "R4");
    chkRd(3'd5, 32'h0, "R4");

    // R5 output enable and level
    wr(3'd0, 32'h0400_0001);
    want(SEL_OE, 1, "R5", 0);
    want(SEL_OUT, 1, "R5", 0);
    tick();
    wr(3'd0, 32'h0400_0000);
    want(SEL_OE, 1, "R5", 0);
    want(SEL_OUT, 0, "R5", 0);
    tick();

    // R3 input read-back and its latency
    busAddr = 3'd0; busRe = 1'b1;
    padIn = 1'b1;
    want(SEL_RD, 32'h0400_0000, "R3", 1);
    want(SEL_RD, 32'h0400_0002, "R3", 2);
    want(SEL_EV, 0, "R10", 2);
    tick(3);
    wr(3'd0, 32'h0400_0000);
    want(SEL_RD, 32'h0400_0002, "R3", 0);
    tick();
    padIn = 1'b0;
    want(SEL_RD, 32'h0400_0002, "R3", 1);
    want(SEL_RD, 32'h0400_0000, "R3", 2);
    wr(3'd0, 32'h0400_0002);
    tick(2);
    busRe = 1'b0;

    // R10 disabled with inversion
    wr(3'd0, 32'h0480_0000);
    padIn = 1'b1;
    want(SEL_EV, 0, "R10", 2);
    want(SEL_EV, 0, "R10", 3);
    tick(3);
    padIn = 1'b0;
    want(SEL_EV, 0, "R10", 2);
    tick(3);

    // R7 rising edge
    wr(3'd0, 32'h0200_0000);
    tick();
    padIn = 1'b1;
    want(SEL_EV, 0, "R7", 1);
    want(SEL_EV, 1, "R7", 2);
    want(SEL_EV, 0, "R7", 3);
    tick(4);
    padIn = 1'b0;
    want(SEL_EV, 0, "R7", 2);
    want(SEL_EV, 0, "R7", 3);
    tick(4);

    // R8 falling edge through inversion
    wr(3'd0, 32'h0280_0000);
    tick(3);
    padIn = 1'b1;
    want(SEL_EV, 0, "R8", 2);
    want(SEL_EV, 0, "R8", 3);
    tick(4);
    padIn = 1'b0;
    want(SEL_EV, 1, "R8", 2);
    want(SEL_EV, 0, "R8", 3);
    tick(4);

    // R9 both edges
    wr(3'd0, 32'h0600_0000);
    tick(3);
    padIn = 1'b1;
    want(SEL_EV, 1, "R9", 2);
    want(SEL_EV, 0, "R9", 3);
    tick(4);
    padIn = 1'b0;
    want(SEL_EV, 1, "R9", 2);
    want(SEL_EV, 0, "R9", 3);
    tick(4);
    padIn = 1'b1;
    want(SEL_EV, 1, "R9", 2);
    want(SEL_EV, 1, "R9", 3);
    want(SEL_EV, 0, "R9", 4);
    tick();
    padIn = 1'b0;
    tick(5);

    // R6 high level held
    wr(3'd0, 32'h0000_0000);
    tick();
    padIn = 1'b1;
    want(SEL_EV, 0, "R6", 1);
    want(SEL_EV, 1, "R6", 2);
    want(SEL_EV, 1, "R6", 3);
    want(SEL_EV, 1, "R6", 4);
    want(SEL_EV, 1, "R6", 5);
    tick(6);
    padIn = 1'b0;
    want(SEL_EV, 1, "R6", 1);
    want(SEL_EV, 0, "R6", 2);
    tick(3);

    // R8 low level through inversion
    wr(3'd0, 32'h0080_0000);
    want(SEL_EV, 1, "R8", 0);
    tick();
    padIn = 1'b1;
    want(SEL_EV, 1, "R8", 1);
    want(SEL_EV, 0, "R8", 2);
    tick(3);

    // R11 receive-off forces the detector input low
    wr(3'd0, 32'h0080_0200);
    want(SEL_EV, 1, "R11", 0);
    chkRd(3'd0, 32'h0080_0200, "R11");
    padIn = 1'b0;
    tick(2);
    padIn = 1'b1;
    want(SEL_EV, 1, "R11", 2);
    want(SEL_EV, 1, "R11", 3);
    tick(4);
    wr(3'd0, 32'h0000_0200);
    want(SEL_EV, 0, "R11", 0);
    want(SEL_EV, 0, "R11", 2);
    tick(4);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule